// File: doc/BRIEF.md
# Load/Store Multiple Word Sequencer

This block steps through one load-multiple or store-multiple word instruction. A start pulse hands it a 32-bit instruction word and the value of the base register. From the word it takes a first register, a transfer count, a signed byte offset, the direction and whether unaligned addresses are allowed. It then issues one 32-bit memory transfer per step on a request/ready interface. A load writes each returned word into the next register through a write port of a 32-entry register file. A store reads the next register through a combinational read port and sends that value to memory.

The register number advances by one on each step and wraps modulo 32. When the first register lies in the upper half of the file, the number stays in the upper half. A store whose first register is 0 stores register 0, which reads as zero, on every step. When the sequence ends the block gives a one-cycle done pulse. In the aligned variant, a misaligned address gives a one-cycle alignment-fault pulse instead, and the sequence ends without any transfer.

Top module: `lsm_seq`

## Requirements
- R1: The transfer count comes from instruction bits 14:12. Codes 1 to 7 give that many transfers and code 0 gives eight.
- R2: The byte offset is a 9-bit signed value. Bit 8 (the sign) comes from instruction bit 15 and bits 7:0 from instruction bits 7:0. Step n (counting from 0) uses address base + offset + 4*n.
- R3: The first register number comes from instruction bits 25:21 (called rt). Step n uses register ((rt + n) mod 32) OR (rt AND 16), so a sequence that starts in registers 16 to 31 never leaves them.
- R4: Instruction bit 11 selects the direction, 0 for load and 1 for store. A load writes mem_rdata into the step's register and keeps mem_we low. A store drives mem_we high, drives rf_raddr with the step's register and drives mem_wdata with rf_rdata.
- R5: A store with rt = 0 presents register 0 on rf_raddr on every step, so every stored word is zero.
- R6: A load step that targets register 0 keeps rf_we low, so register 0 is never written.
- R7: Instruction bits 10:8 equal to 3'b101 allow any address. Every other value of those bits selects the aligned variant. In the aligned variant, a step address with nonzero bits 1:0 makes align_fault pulse for one cycle in the cycle after that step is reached. No memory request or register write is made, and busy falls.
- R8: The instruction and base are captured on the clock edge where start is high while the block is idle. Later changes on those inputs, and start pulses while busy, have no effect.
- R9: A step holds mem_req, mem_addr and mem_we steady until mem_ready is high. A step completes in a cycle where mem_req and mem_ready are both high.
- R10: done is high for exactly one cycle, the cycle after the last transfer completes. busy is low in that cycle.
- R11: After reset busy, done, align_fault, mem_req and rf_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only while idle) |
| instr | input | 32 | Instruction word |
| base | input | 32 | Base register value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the last transfer |
| align_fault | output | 1 | One-cycle pulse on a misaligned aligned-variant address |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Request is a write (store) |
| mem_addr | output | 32 | Byte address of the transfer |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts or completes the transfer this cycle |
| mem_rdata | input | 32 | Load data, valid while mem_ready is high |
| rf_raddr | output | 5 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |

## Verification
A wrong step counter or a badly captured count shows up at the ports as the wrong number of accepted transfers, or as a done pulse that comes one or more steps early or late. A wrong register or address for any step shows in the same cycle that step completes, on rf_raddr, rf_waddr, mem_addr or mem_wdata. An alignment decision that latched the wrong value shows one cycle after start: a fault pulse appears where a request should be, or the other way round. Wait states from memory check that a step holds its request steady, and a second start pulse during a busy sequence checks that the captured operation cannot be overwritten.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    // datapath and register file geometry
    localparam int XLEN     = 32;
    localparam int RF_AW    = 5;
    localparam int CNT_W    = 3;
    localparam int SUB_W    = 3;
    localparam int OFF_W    = 9;

    // instruction field positions
    localparam int RT_LSB   = 21;
    localparam int CNT_LSB  = 12;
    localparam int DIR_BIT  = 11;
    localparam int SUB_LSB  = 8;
    localparam int OFFS_BIT = 15;
    localparam int OFFL_W   = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e          st;
        logic [CNT_W-1:0]    step;
        logic [CNT_W-1:0]    last;
        logic                store;
        logic                unal_ok;
        logic [RF_AW-1:0]    rt;
        logic [XLEN-1:0]     addr0;
        logic                done;
        logic                fault;
    } seq_ctl_t;

    localparam seq_ctl_t SEQ_CTL_RESET = '{
        st:      ST_IDLE,
        step:    '0,
        last:    '0,
        store:   1'b0,
        unal_ok: 1'b0,
        rt:      '0,
        addr0:   '0,
        done:    1'b0,
        fault:   1'b0
    };

endpackage

// File: rtl/lsm_decode.sv
module lsm_decode
    import lsm_pkg::*;
#(
    parameter logic [SUB_W-1:0] UNAL_SUBOP = 3'b101
) (
    input  logic [XLEN-1:0]  instr,
    input  logic [XLEN-1:0]  base,
    output logic [RF_AW-1:0] rt,
    output logic             is_store,
    output logic             unal_ok,
    output logic [CNT_W-1:0] last_step,
    output logic [XLEN-1:0]  first_addr
);

    localparam int SEXT_W = XLEN - OFF_W;

    logic [OFF_W-1:0] off9;
    logic [XLEN-1:0]  off_ext;
    logic [CNT_W-1:0] cnt_code;
    logic             unused_fields;

    assign unused_fields = ^{instr[XLEN-1:RT_LSB+RF_AW], instr[RT_LSB-1:OFFS_BIT+1]};

    assign rt        = instr[RT_LSB +: RF_AW];
    assign is_store  = instr[DIR_BIT];
    assign unal_ok   = (instr[SUB_LSB +: SUB_W] == UNAL_SUBOP);
    assign cnt_code  = instr[CNT_LSB +: CNT_W];

    // code 0 means the full 2**CNT_W transfers: the last index wraps to all ones
    assign last_step = cnt_code - CNT_W'(1);

    assign off9      = {instr[OFFS_BIT], instr[OFFL_W-1:0]};
    assign off_ext   = {{SEXT_W{off9[OFF_W-1]}}, off9};
    assign first_addr = base + off_ext;

endmodule

// File: rtl/lsm_step_gen.sv
module lsm_step_gen
    import lsm_pkg::*;
(
    input  logic [RF_AW-1:0] rt,
    input  logic             is_store,
    input  logic [CNT_W-1:0] step,
    input  logic [XLEN-1:0]  addr0,
    output logic [XLEN-1:0]  addr,
    output logic [RF_AW-1:0] reg_idx
);

    logic [RF_AW-1:0] sum;
    logic [RF_AW-1:0] half_keep;

    assign addr      = addr0 + XLEN'({step, 2'b00});
    assign sum       = rt + RF_AW'(step);
    assign half_keep = {rt[RF_AW-1], {(RF_AW-1){1'b0}}};

    always_comb begin
        if (is_store && (rt == '0)) begin
            reg_idx = '0;
        end else begin
            reg_idx = sum | half_keep;
        end
    end

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter logic [SUB_W-1:0] UNAL_SUBOP = 3'b101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [31:0]       base,
    output logic              busy,
    output logic              done,
    output logic              align_fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic [4:0]        rf_raddr,
    input  logic [31:0]       rf_rdata,
    output logic              rf_we,
    output logic [4:0]        rf_waddr,
    output logic [31:0]       rf_wdata
);

    seq_ctl_t c_d, c_q;

    logic [RF_AW-1:0] dec_rt;
    logic             dec_store;
    logic             dec_unal;
    logic [CNT_W-1:0] dec_last;
    logic [XLEN-1:0]  dec_addr0;

    logic [XLEN-1:0]  step_addr;
    logic [RF_AW-1:0] step_idx;
    logic             misaligned;
    logic             req_d;
    logic             rf_we_d;

    lsm_decode #(
        .UNAL_SUBOP (UNAL_SUBOP)
    ) i_decode (
        .instr      (instr),
        .base       (base),
        .rt         (dec_rt),
        .is_store   (dec_store),
        .unal_ok    (dec_unal),
        .last_step  (dec_last),
        .first_addr (dec_addr0)
    );

    lsm_step_gen i_step_gen (
        .rt       (c_q.rt),
        .is_store (c_q.store),
        .step     (c_q.step),
        .addr0    (c_q.addr0),
        .addr     (step_addr),
        .reg_idx  (step_idx)
    );

    assign misaligned = !c_q.unal_ok && (step_addr[1:0] != 2'b00);

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        c_d.fault = 1'b0;
        req_d     = 1'b0;
        rf_we_d   = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st      = ST_RUN;
                    c_d.step    = '0;
                    c_d.last    = dec_last;
                    c_d.store   = dec_store;
                    c_d.unal_ok = dec_unal;
                    c_d.rt      = dec_rt;
                    c_d.addr0   = dec_addr0;
                end
            end
            ST_RUN: begin
                if (misaligned) begin
                    c_d.fault = 1'b1;
                    c_d.st    = ST_IDLE;
                end else begin
                    req_d = 1'b1;
                    if (mem_ready) begin
                        rf_we_d = !c_q.store && (step_idx != '0);
                        if (c_q.step == c_q.last) begin
                            c_d.done = 1'b1;
                            c_d.st   = ST_IDLE;
                        end else begin
                            c_d.step = c_q.step + CNT_W'(1);
                        end
                    end
                end
            end
            default: c_d = SEQ_CTL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= SEQ_CTL_RESET;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy        = (c_q.st == ST_RUN);
    assign done        = c_q.done;
    assign align_fault = c_q.fault;
    assign mem_req     = req_d;
    assign mem_we      = req_d && c_q.store;
    assign mem_addr    = step_addr;
    assign mem_wdata   = rf_rdata;
    assign rf_raddr    = step_idx;
    assign rf_we       = rf_we_d;
    assign rf_waddr    = step_idx;
    assign rf_wdata    = mem_rdata;

    // R9: an unaccepted request stays in place
    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2: consecutive steps are one word apart
    a_r2_word_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && (c_q.step != c_q.last)) |=>
            (mem_req && (mem_addr == $past(mem_addr) + 32'd4)));

    // R3: a sequence started in the upper half stays there
    a_r3_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && c_q.rt[RF_AW-1]) |-> rf_raddr[RF_AW-1]);

    // R6: register 0 is never written
    a_r6_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != 5'd0));

    // R4: a store never writes the register file
    a_r4_store_no_rf_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rf_we);

    // R5: store from rt 0 reads only register 0
    a_r5_zero_store: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (c_q.rt == 5'd0)) |-> (rf_raddr == 5'd0));

    // R7: a fault ends the sequence without completion
    a_r7_fault_ends: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (!done && !busy && !mem_req));

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/test_lsm_seq.sv
module test_lsm_seq;

    localparam logic [31:0] MAGIC = 32'h5A5A_0F0F;

    typedef struct packed {
        logic [4:0]  rt;
        logic        dir;
        logic [2:0]  sub;
        logic [2:0]  cnt;
        logic [8:0]  off;
        logic [31:0] base;
        logic [1:0]  waitc;
        logic [3:0]  expn;
        logic        expf;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{5'd4,  1'b0, 3'b100, 3'd3, 9'h008, 32'h0000_1000, 2'd0, 4'd3, 1'b0},
        '{5'd14, 1'b1, 3'b100, 3'd0, 9'h1FC, 32'h0000_2000, 2'd2, 4'd8, 1'b0},
        '{5'd29, 1'b0, 3'b101, 3'd5, 9'h003, 32'h0000_3000, 2'd1, 4'd5, 1'b0},
        '{5'd0,  1'b1, 3'b100, 3'd2, 9'h000, 32'h0000_0040, 2'd0, 4'd2, 1'b0},
        '{5'd0,  1'b0, 3'b100, 3'd3, 9'h010, 32'h0000_0080, 2'd1, 4'd3, 1'b0},
        '{5'd7,  1'b1, 3'b100, 3'd4, 9'h002, 32'h0000_0100, 2'd0, 4'd0, 1'b1},
        '{5'd20, 1'b0, 3'b100, 3'd1, 9'h100, 32'h0000_1000, 2'd0, 4'd1, 1'b0},
        '{5'd31, 1'b1, 3'b011, 3'd2, 9'h001, 32'h0000_0200, 2'd0, 4'd0, 1'b1},
        '{5'd17, 1'b1, 3'b101, 3'd6, 9'h0FF, 32'h0000_0500, 2'd0, 4'd6, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base = '0;
    logic        busy, done, align_fault, mem_req, mem_we, rf_we;
    logic [31:0] mem_addr, mem_wdata, rf_wdata, rf_rdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [4:0]  rf_raddr, rf_waddr;

    logic [31:0] rf [32];

    int total = 0;
    int failed = 0;

    logic [31:0] lg_addr [16];
    logic [31:0] lg_wdata [16];
    logic [31:0] lg_rfdata [16];
    logic [4:0]  lg_raddr [16];
    logic [4:0]  lg_waddr [16];
    logic        lg_we [16];
    logic        lg_rfwe [16];

    always #10 clk = ~clk;

    assign rf_rdata = (rf_raddr == 5'd0) ? 32'd0 : rf[rf_raddr];

    lsm_seq i_lsm_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .instr       (instr),
        .base        (base),
        .busy        (busy),
        .done        (done),
        .align_fault (align_fault),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .rf_raddr    (rf_raddr),
        .rf_rdata    (rf_rdata),
        .rf_we       (rf_we),
        .rf_waddr    (rf_waddr),
        .rf_wdata    (rf_wdata)
    );

    function automatic logic [31:0] rf_init(input int i);
        return (i == 0) ? 32'd0 : (32'hC000_0000 | (32'(i) * 32'h0001_0101));
    endfunction

    function automatic logic [31:0] mk_instr(input vec_t v);
        return {6'b101001, v.rt, 5'd9, v.off[8], v.cnt, v.dir, v.sub, v.off[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reinit_rf();
        for (int i = 0; i < 32; i++) rf[i] = rf_init(i);
    endtask

    // drive one operation and log every accepted transfer
    task automatic run_op(input vec_t v, input bit poke, output int n, output bit flt, output int hold_err);
        int wc;
        int guard;
        bit first;
        bit held;
        logic [31:0] prev;
        @(negedge clk);
        start = 1'b1;
        instr = mk_instr(v);
        base  = v.base;
        @(negedge clk);
        start = 1'b0;
        instr = 32'hFFFF_FFFF;
        base  = 32'hDEAD_BEEF;
        n = 0; flt = 1'b0; wc = 0; guard = 0; first = 1'b1; held = 1'b0;
        hold_err = 0; prev = '0;
        forever begin
            if (first && poke) begin
                start = 1'b1;
                instr = {6'b0, 5'd1, 5'd0, 1'b0, 3'd1, 1'b0, 3'b101, 8'h00};
            end else begin
                start = 1'b0;
            end
            first = 1'b0;
            if (done) break;
            if (align_fault) begin
                flt = 1'b1;
                break;
            end
            if (mem_req) begin
                if (wc < int'(v.waitc)) begin
                    if (held && (mem_addr != prev)) hold_err++;
                    mem_ready = 1'b0;
                    prev = mem_addr;
                    held = 1'b1;
                    wc++;
                end else begin
                    if (held && (mem_addr != prev)) hold_err++;
                    mem_ready = 1'b1;
                    mem_rdata = mem_addr ^ MAGIC;
                    #1;
                    if (n < 16) begin
                        lg_addr[n]   = mem_addr;
                        lg_wdata[n]  = mem_wdata;
                        lg_raddr[n]  = rf_raddr;
                        lg_we[n]     = mem_we;
                        lg_rfwe[n]   = rf_we;
                        lg_waddr[n]  = rf_waddr;
                        lg_rfdata[n] = rf_wdata;
                    end
                    if (rf_we) rf[rf_waddr] = rf_wdata;
                    n++;
                    wc = 0;
                    held = 1'b0;
                end
            end else begin
                mem_ready = 1'b0;
            end
            guard++;
            if (guard > 100) break;
            @(negedge clk);
        end
        mem_ready = 1'b0;
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        int n;
        bit flt;
        int hold_err;
        reinit_rf();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(!busy && !done && !align_fault && !mem_req && !rf_we, "R11 reset outputs",
            {27'd0, busy, done, align_fault, mem_req, rf_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R11 idle after reset", {30'd0, busy, mem_req}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] off_ext;
            int expn;
            v = VECS[i];
            reinit_rf();
            run_op(v, (i == 1), n, flt, hold_err);
            off_ext = {{23{v.off[8]}}, v.off};
            expn = (v.cnt == 3'd0) ? 8 : int'(v.cnt);
            // R1 / R7: number of transfers and fault outcome
            chk(n == int'(v.expn), "R1 transfer count", 32'(n), 32'(v.expn));
            chk(flt == v.expf, "R7 fault outcome", {31'd0, flt}, {31'd0, v.expf});
            if (!v.expf) begin
                chk(n == expn, "R1 count decode", 32'(n), 32'(expn));
            end
            chk(hold_err == 0, "R9 request held during wait", 32'(hold_err), 32'd0);
            if (i == 1) begin
                chk(n == 8, "R8 start while busy ignored", 32'(n), 32'd8);
            end
            for (int k = 0; k < n && k < 16; k++) begin
                logic [31:0] ea;
                logic [4:0]  ei;
                ea = v.base + off_ext + 32'(4 * k);
                ei = (v.dir && v.rt == 5'd0) ? 5'd0 :
                     (5'(v.rt + 5'(k)) | (v.rt & 5'd16));
                chk(lg_addr[k] == ea, "R2 step address", lg_addr[k], ea);
                chk(lg_we[k] == v.dir, "R4 direction", {31'd0, lg_we[k]}, {31'd0, v.dir});
                if (v.dir) begin
                    chk(lg_raddr[k] == ei, "R3 store register", {27'd0, lg_raddr[k]}, {27'd0, ei});
                    chk(lg_wdata[k] == rf_init(int'(ei)), (v.rt == 5'd0) ? "R5 zero store data" : "R4 store data",
                        lg_wdata[k], rf_init(int'(ei)));
                    chk(!lg_rfwe[k], "R4 store leaves file", {31'd0, lg_rfwe[k]}, 32'd0);
                end else if (ei == 5'd0) begin
                    chk(!lg_rfwe[k], "R6 register 0 write dropped", {31'd0, lg_rfwe[k]}, 32'd0);
                end else begin
                    chk(lg_rfwe[k] && lg_waddr[k] == ei, "R3 load register",
                        {26'd0, lg_rfwe[k], lg_waddr[k]}, {26'd0, 1'b1, ei});
                    chk(lg_rfdata[k] == (ea ^ MAGIC), "R4 load data", lg_rfdata[k], ea ^ MAGIC);
                end
            end
            if (flt) begin
                chk(!busy && !mem_req, "R7 fault ends sequence", {30'd0, busy, mem_req}, 32'd0);
            end else begin
                chk(!busy, "R10 idle with done", {31'd0, busy}, 32'd0);
            end
            @(negedge clk);
            chk(!done && !align_fault, "R10 single-cycle pulse", {30'd0, done, align_fault}, 32'd0);
        end

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule